// File: doc/BRIEF.md
# Staged Pipeline Control Unit

This block turns the instruction word sitting in the decode stage of a five-stage processor pipeline into the control bundle for that instruction, and then hands each part of the bundle down the pipeline so that it arrives at the stage that uses it. The execute controls arrive one clock after decode. The memory controls arrive two clocks after decode. The write-back controls arrive three clocks after decode. Each pipeline register holds only the fields that later stages still need: the first holds the whole bundle, the second holds the memory and write-back fields, and the last holds the write-back fields only.

At any stage the controls come only from the instruction that is in that stage. A bubble request from the hazard logic turns the instruction that is being decoded into a no-op. A synchronous active-low reset empties all three registers. The datapath registers, hazard detection and forwarding belong to other blocks.

Top module: `pipe_ctrl_stager`

## Requirements
- R1: The execute-stage outputs (`ex_sign_ext`, `ex_use_imm`, `ex_alu_fn`, `ex_dest_rd`) show the decode of the instruction that was on `instr` at the previous rising edge.
- R2: The memory-stage outputs (`mem_store_en`, `mem_branch`) show the decode of the instruction that was presented two rising edges earlier.
- R3: The write-back outputs (`wb_from_mem`, `wb_reg_en`) show the decode of the instruction that was presented three rising edges earlier.
- R4: Opcode bits [31:26] = 0x23 (load word) decode to sign_ext=1, use_imm=1, alu_fn=ADD, dest_rd=0, store_en=0, branch=0, from_mem=1, reg_en=1.
- R5: Opcode 0x00 (register-register) decodes to sign_ext=0, use_imm=0, dest_rd=1, store_en=0, branch=0, from_mem=0, reg_en=1. The ALU function comes from funct bits [5:0]: 0x20 gives ADD, 0x22 gives SUB, 0x24 gives AND, 0x25 gives OR, and 0x2A gives SLT.
- R6: Opcode 0x2B (store word) decodes to sign_ext=1, use_imm=1, alu_fn=ADD, dest_rd=0, store_en=1, branch=0, from_mem=0, reg_en=0.
- R7: Opcode 0x04 (branch on equal) decodes to alu_fn=SUB, branch=1, and 0 on every other control.
- R8: Any other opcode, or a register-register funct not listed in R5, decodes to all controls 0 (alu_fn=NONE). ALU function codes: NONE=0, ADD=1, SUB=2, AND=3, OR=4, SLT=5.
- R9: When `bubble_req` is high at a rising edge, the instruction on `instr` is replaced by an all-zero bundle. That bundle appears on the execute, memory and write-back outputs on the following edges in turn.
- R10: When `rst_n` is low at a rising edge, every output is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word in the decode stage |
| bubble_req | input | 1 | Replace the decoding instruction with a no-op |
| ex_sign_ext | output | 1 | Execute: sign-extend the immediate |
| ex_use_imm | output | 1 | Execute: second ALU operand is the immediate |
| ex_alu_fn | output | 3 | Execute: ALU function code |
| ex_dest_rd | output | 1 | Execute: destination is rd (0 selects rt) |
| mem_store_en | output | 1 | Memory: write data memory |
| mem_branch | output | 1 | Memory: branch instruction |
| wb_from_mem | output | 1 | Write-back: result comes from memory |
| wb_reg_en | output | 1 | Write-back: write the register file |

## Verification
The bench builds the block with its default 32-bit instruction word and 6-bit opcode and funct fields. At these widths every one of the 64 opcodes can be swept with a fixed funct, and every one of the 64 functs can be swept under the register-register opcode. The instructions go in back to back, so each check covers all three stage delays at once. Bubbles placed at regular positions in the stream and a reset in the middle of a run show the zero bundle moving down the pipeline.

// File: rtl/pipe_ctrl_pkg.sv
// Shared control types for the staged pipeline control unit.
// Assumes the opcode is in the top bits and the funct in the low bits of the instruction.
package pipe_ctrl_pkg;

    localparam int ALU_FN_W = 3;

    typedef enum logic [ALU_FN_W-1:0] {
        ALU_NONE = 3'd0,
        ALU_ADD  = 3'd1,
        ALU_SUB  = 3'd2,
        ALU_AND  = 3'd3,
        ALU_OR   = 3'd4,
        ALU_SLT  = 3'd5
    } alu_fn_t;

    typedef struct packed {
        logic    sign_ext;
        logic    use_imm;
        alu_fn_t alu_fn;
        logic    dest_rd;
    } ex_ctrl_t;

    typedef struct packed {
        logic store_en;
        logic branch;
    } mem_ctrl_t;

    typedef struct packed {
        logic from_mem;
        logic reg_en;
    } wb_ctrl_t;

    typedef struct packed {
        ex_ctrl_t  ex;
        mem_ctrl_t mem;
        wb_ctrl_t  wb;
    } full_ctrl_t;

    typedef struct packed {
        mem_ctrl_t mem;
        wb_ctrl_t  wb;
    } late_ctrl_t;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/pipe_ctrl_decoder.sv
// Combinational main decoder: maps opcode and funct to a full control bundle.
// Assumes the opcode occupies the top OP_W bits and the funct the low FN_W bits.
// Controls that do not matter are driven to 0. Unknown encodings give an all-zero bundle.
module pipe_ctrl_decoder
    import pipe_ctrl_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OP_W    = 6,
    parameter int FN_W    = 6
) (
    input  logic [INSTR_W-1:0] instr_i,
    output full_ctrl_t         ctrl_o
);
    localparam int OP_LSB = INSTR_W - OP_W;

    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fnc;

    assign opc = instr_i[INSTR_W-1:OP_LSB];
    assign fnc = instr_i[FN_W-1:0];

    // Translate the funct field of a register-register instruction into an ALU code.
    function automatic alu_fn_t reg_fn(input logic [FN_W-1:0] f);
        case (6'(f))
            FN_ADD:  return ALU_ADD;
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_NONE;
        endcase
    endfunction

    // Build the whole bundle from the opcode, starting from all zeros.
    always_comb begin
        ctrl_o = '0;
        case (6'(opc))
            OPC_LOAD: begin
                ctrl_o.ex.sign_ext = 1'b1;
                ctrl_o.ex.use_imm  = 1'b1;
                ctrl_o.ex.alu_fn   = ALU_ADD;
                ctrl_o.wb.from_mem = 1'b1;
                ctrl_o.wb.reg_en   = 1'b1;
            end
            OPC_STORE: begin
                ctrl_o.ex.sign_ext  = 1'b1;
                ctrl_o.ex.use_imm   = 1'b1;
                ctrl_o.ex.alu_fn    = ALU_ADD;
                ctrl_o.mem.store_en = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_o.ex.alu_fn  = ALU_SUB;
                ctrl_o.mem.branch = 1'b1;
            end
            OPC_REG: begin
                if (reg_fn(fnc) != ALU_NONE) begin
                    ctrl_o.ex.alu_fn  = reg_fn(fnc);
                    ctrl_o.ex.dest_rd = 1'b1;
                    ctrl_o.wb.reg_en  = 1'b1;
                end
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/pipe_ctrl_stage_reg.sv
// One pipeline register of width W for control fields.
// A synchronous active-low reset or the clear input loads zeros, otherwise it loads d_i.
module pipe_ctrl_stage_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the incoming control fields, or empty the register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) q_o <= '0;
        else                 q_o <= d_i;
    end

endmodule

// File: rtl/pipe_ctrl_stager.sv
// Staged pipeline control unit: decodes the instruction in decode and moves the
// bundle through three registers, each narrower than the one before.
// Assumes the hazard logic raises bubble_req in the cycle it wants a no-op in execute.
module pipe_ctrl_stager
    import pipe_ctrl_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int OP_W    = 6,
    parameter int FN_W    = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr,
    input  logic                bubble_req,
    output logic                ex_sign_ext,
    output logic                ex_use_imm,
    output logic [ALU_FN_W-1:0] ex_alu_fn,
    output logic                ex_dest_rd,
    output logic                mem_store_en,
    output logic                mem_branch,
    output logic                wb_from_mem,
    output logic                wb_reg_en
);
    localparam int FULL_W = $bits(full_ctrl_t);
    localparam int LATE_W = $bits(late_ctrl_t);
    localparam int WB_W   = $bits(wb_ctrl_t);

    full_ctrl_t dec_ctrl;
    full_ctrl_t idex_q;
    late_ctrl_t exmem_d;
    late_ctrl_t exmem_q;
    wb_ctrl_t   memwb_q;

    pipe_ctrl_decoder #(
        .INSTR_W (INSTR_W),
        .OP_W    (OP_W),
        .FN_W    (FN_W)
    ) u_dec (
        .instr_i (instr),
        .ctrl_o  (dec_ctrl)
    );

    pipe_ctrl_stage_reg #(.W(FULL_W)) u_idex (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (bubble_req),
        .d_i   (dec_ctrl),
        .q_o   (idex_q)
    );

    assign exmem_d.mem = idex_q.mem;
    assign exmem_d.wb  = idex_q.wb;

    pipe_ctrl_stage_reg #(.W(LATE_W)) u_exmem (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (1'b0),
        .d_i   (exmem_d),
        .q_o   (exmem_q)
    );

    pipe_ctrl_stage_reg #(.W(WB_W)) u_memwb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (1'b0),
        .d_i   (exmem_q.wb),
        .q_o   (memwb_q)
    );

    assign ex_sign_ext  = idex_q.ex.sign_ext;
    assign ex_use_imm   = idex_q.ex.use_imm;
    assign ex_alu_fn    = idex_q.ex.alu_fn;
    assign ex_dest_rd   = idex_q.ex.dest_rd;
    assign mem_store_en = exmem_q.mem.store_en;
    assign mem_branch   = exmem_q.mem.branch;
    assign wb_from_mem  = memwb_q.from_mem;
    assign wb_reg_en    = memwb_q.reg_en;

endmodule

// File: rtl/pipe_ctrl_stager_chk.sv
// Checker for the staged control unit, bound to the top module.
// Assumes it sees the top's ports and the ID/Ex and Ex/Mem register contents.
module pipe_ctrl_stager_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bubble_req,
    input logic       ex_sign_ext,
    input logic       ex_use_imm,
    input logic [2:0] ex_alu_fn,
    input logic       ex_dest_rd,
    input logic       mem_store_en,
    input logic       mem_branch,
    input logic       wb_from_mem,
    input logic       wb_reg_en,
    input logic [3:0] idex_late,
    input logic [1:0] exmem_wb
);
    logic seen_edge;

    // Note that at least one clock edge has passed.
    always_ff @(posedge clk) seen_edge <= 1'b1;

    AST_MEM_FROM_IDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n)) |-> ({mem_store_en, mem_branch} == $past(idex_late[3:2]))); // R2

    AST_WB_FROM_EXMEM: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(rst_n)) |-> ({wb_from_mem, wb_reg_en} == $past(exmem_wb))); // R3

    AST_BUBBLE_EMPTIES_EX: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $past(bubble_req)) |->
            ({ex_sign_ext, ex_use_imm, ex_alu_fn, ex_dest_rd, idex_late} == '0)); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && $rose(rst_n)) |->
            ({ex_sign_ext, ex_use_imm, ex_alu_fn, ex_dest_rd, mem_store_en, mem_branch,
              wb_from_mem, wb_reg_en} == '0)); // R10

    AST_STORE_XOR_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> $onehot0({mem_store_en, mem_branch})); // R6

    AST_MEM_RESULT_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && wb_from_mem) |-> wb_reg_en); // R4

endmodule

bind pipe_ctrl_stager pipe_ctrl_stager_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bubble_req   (bubble_req),
    .ex_sign_ext  (ex_sign_ext),
    .ex_use_imm   (ex_use_imm),
    .ex_alu_fn    (ex_alu_fn),
    .ex_dest_rd   (ex_dest_rd),
    .mem_store_en (mem_store_en),
    .mem_branch   (mem_branch),
    .wb_from_mem  (wb_from_mem),
    .wb_reg_en    (wb_reg_en),
    .idex_late    ({idex_q.mem, idex_q.wb}),
    .exmem_wb     (exmem_q.wb)
);

// File: tb/tb_pipe_ctrl_stager.sv
// Bench for the staged control unit: sweeps every opcode and every register funct
// back to back, with bubbles and a reset mid-run, against a model written from the requirements.
module tb_pipe_ctrl_stager;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        bubble_req = 1'b0;
    logic        ex_sign_ext, ex_use_imm, ex_dest_rd;
    logic [2:0]  ex_alu_fn;
    logic        mem_store_en, mem_branch, wb_from_mem, wb_reg_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Expected bundle bits: {sign_ext, use_imm, fn[2:0], dest_rd, store_en, branch, from_mem, reg_en}
    logic [9:0] m_ex = '0;
    logic [3:0] m_mem = '0;
    logic [1:0] m_wb = '0;
    string t_ex = "R10", t_mem = "R10", t_wb = "R10";

    pipe_ctrl_stager dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr        (instr),
        .bubble_req   (bubble_req),
        .ex_sign_ext  (ex_sign_ext),
        .ex_use_imm   (ex_use_imm),
        .ex_alu_fn    (ex_alu_fn),
        .ex_dest_rd   (ex_dest_rd),
        .mem_store_en (mem_store_en),
        .mem_branch   (mem_branch),
        .wb_from_mem  (wb_from_mem),
        .wb_reg_en    (wb_reg_en)
    );

    always #2 clk = ~clk;

    // Reference decode, written from R4 to R8.
    function automatic logic [9:0] ref_dec(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        case (op)
            6'h23: return {1'b1, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            6'h2B: return {1'b1, 1'b1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
            6'h04: return {1'b0, 1'b0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
            6'h00: begin
                case (fn)
                    6'h20: return {2'b00, 3'd1, 1'b1, 4'b0001};
                    6'h22: return {2'b00, 3'd2, 1'b1, 4'b0001};
                    6'h24: return {2'b00, 3'd3, 1'b1, 4'b0001};
                    6'h25: return {2'b00, 3'd4, 1'b1, 4'b0001};
                    6'h2A: return {2'b00, 3'd5, 1'b1, 4'b0001};
                    default: return '0;
                endcase
            end
            default: return '0;
        endcase
    endfunction

    // Requirement tag for the decode case of a word.
    function automatic string tag_of(input logic [31:0] w, input logic bub);
        if (bub) return "R9";
        case (w[31:26])
            6'h23: return "R4";
            6'h2B: return "R6";
            6'h04: return "R7";
            6'h00: return (ref_dec(w) == '0) ? "R8" : "R5";
            default: return "R8";
        endcase
    endfunction

    // Compare all three stage groups against the model.
    task automatic check_outputs();
        checks++;
        if ({ex_sign_ext, ex_use_imm, ex_alu_fn, ex_dest_rd} !== m_ex[9:4]) begin
            errors++;
            $display("FAIL R1 %s ex: got %b expected %b", t_ex,
                     {ex_sign_ext, ex_use_imm, ex_alu_fn, ex_dest_rd}, m_ex[9:4]);
        end
        checks++;
        if ({mem_store_en, mem_branch} !== m_mem[3:2]) begin
            errors++;
            $display("FAIL R2 %s mem: got %b expected %b", t_mem,
                     {mem_store_en, mem_branch}, m_mem[3:2]);
        end
        checks++;
        if ({wb_from_mem, wb_reg_en} !== m_wb) begin
            errors++;
            $display("FAIL R3 %s wb: got %b expected %b", t_wb,
                     {wb_from_mem, wb_reg_en}, m_wb);
        end
    endtask

    // One cycle: check at the falling edge, drive new inputs, advance the model.
    task automatic step(input logic [31:0] w, input logic bub, input logic rst);
        @(negedge clk);
        check_outputs();
        instr = w;
        bubble_req = bub;
        rst_n = rst;
        if (!rst) begin
            m_ex = '0; m_mem = '0; m_wb = '0;
            t_ex = "R10"; t_mem = "R10"; t_wb = "R10";
        end else begin
            m_wb = m_mem[1:0];
            t_wb = t_mem;
            m_mem = m_ex[3:0];
            t_mem = t_ex;
            m_ex = bub ? 10'd0 : ref_dec(w);
            t_ex = tag_of(w, bub);
        end
    endtask

    initial begin
        int n = 0;
        // R10: hold reset, then check the cleared state.
        step(32'h8C22_0100, 1'b0, 1'b0);
        step(32'h8C22_0100, 1'b0, 1'b0);
        // R4 R6 R7 R8: every opcode with a fixed funct, bubble every seventh word (R9).
        for (int op = 0; op < 64; op++) begin
            step({op[5:0], 20'h4A2B1, 6'h20}, (n % 7) == 3, 1'b1);
            n++;
        end
        // R5 R8: every funct under the register-register opcode.
        for (int fn = 0; fn < 64; fn++) begin
            step({6'h00, 20'h3C5E7, fn[5:0]}, (n % 7) == 3, 1'b1);
            n++;
        end
        // R9: a bubble on a load between back-to-back stores and branches.
        step({6'h2B, 26'h0}, 1'b0, 1'b1);
        step({6'h23, 26'h0}, 1'b1, 1'b1);
        step({6'h04, 26'h0}, 1'b0, 1'b1);
        step({6'h23, 26'h0}, 1'b0, 1'b1);
        // R10: reset in the middle of a full pipeline.
        step({6'h23, 26'h0}, 1'b0, 1'b1);
        step({6'h2B, 26'h0}, 1'b0, 1'b1);
        step({6'h23, 26'h0}, 1'b0, 1'b0);
        step({6'h04, 26'h0}, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) step({6'h00, 20'h0, 6'h2A}, 1'b0, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule